// File: doc/BRIEF.md
# Watchdog Timer With Reset Routing

A memory-mapped watchdog for a 32-bit register bus. Software sets a reload value, writes a fixed key word to the restart register to load the down-counter from it, and then sets the run bit. From then on it has to keep writing the key word. If it stops, the counter runs out: the block latches a timeout flag, reloads the counter, stops and clears its own run bit. Software can therefore poll that bit to learn that the timer has fired.

If the reset-on-expiry bit is set when the counter runs out, the block also drives a reset pulse. The pulse width comes from a register. During the pulse the block presents a 2-bit scope code and two domain vectors. The domain vectors are the stored domain masks gated by the pulse, so a downstream reset controller resets only the domains whose mask bit is set. The counter steps either on every system clock or only on cycles where an external 1 MHz tick input is high.

Top module: `guard_timer`

## Requirements
- R1: After synchronous reset the registers hold these values: the counter (byte offset 0x00) and the reload value (0x04) both equal parameter RELOAD_RST; control (0x0C) is 0; the timeout flag (0x10 bit 0) is 0; pulse width (0x18) is 0xFF; domain mask A (0x1C, 26 bits) is 0x023FFFF3; domain mask B (0x20, 32 bits) is 0. The reset output is low.
- R2: A write of exactly 0x00004755 to offset 0x08 loads the counter from the reload value on that clock edge. Any other value written to 0x08 leaves the counter unchanged.
- R3: Control bit 0 (run) lets the counter step. When control bit 4 is 0, the counter steps on every clock. When bit 4 is 1, it steps only on clocks where tick_i is high. With run clear, the counter holds its value.
- R4: A step taken while the counter is 0 or 1 is an expiry. On expiry the counter reloads, the timeout flag becomes 1, and control bit 0 becomes 0 at the same edge.
- R5: A write to offset 0x14 with bit 0 set clears the timeout flag. A write there with bit 0 clear does nothing. An expiry in the same cycle wins over the clear. timeout_o mirrors the flag.
- R6: An expiry while control bit 1 was set raises rst_o from the next cycle on. rst_o stays high for N cycles, where N is bits 7:0 of 0x18, or for 1 cycle if that field is 0. With control bit 1 clear, rst_o stays low.
- R7: At expiry, control bits 6:5 are captured and driven on rst_scope_o (0 system, 1 whole chip, 2 processor only, 3 reserved). The two domain masks are also captured. rst_dom_a_o and rst_dom_b_o carry the captured masks while rst_o is high and are zero otherwise.
- R8: Writing the reload value while the counter is running does not change the counter. The new value is used at the next restart or expiry.
- R9: Read data appears on rd_data_o one clock after the address is presented. Control reads back bits 7, 6:5, 4, 1 and 0, and the other control bits read as 0. Offsets 0x08 and 0x14, and all unmapped offsets, read as 0.
- R10: A valid restart and an expiry in the same cycle resolve to the restart, with no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 1 MHz count enable pulse, one clock wide |
| addr_i | input | 6 | Byte address of the register |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| timeout_o | output | 1 | Latched timeout flag |
| rst_o | output | 1 | Reset pulse |
| rst_scope_o | output | 2 | Captured reset scope code |
| rst_dom_a_o | output | 26 | Domain mask A gated by the pulse |
| rst_dom_b_o | output | 32 | Domain mask B gated by the pulse |

## Verification
Some properties are checked on every cycle. A valid restart loads the reload value, and the counter holds while stopped. An expiry clears the run bit and sets the flag on the next cycle. Every rising edge of the reset pulse follows an expiry that had reset enabled, and the domain outputs are zero outside a pulse. The bench scenarios are needed for the rest: the exact pulse length and the substitution of 1 for a zero width, the key word being rejected when one bit differs, stepping on ticks only, a reload written mid-count, and restart winning a same-cycle race with expiry. These can only be shown against the reference model, which is compared on every clock.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_COUNT   = 6'h00;
  localparam logic [ADDR_W-1:0] A_RELOAD  = 6'h04;
  localparam logic [ADDR_W-1:0] A_RESTART = 6'h08;
  localparam logic [ADDR_W-1:0] A_CTRL    = 6'h0C;
  localparam logic [ADDR_W-1:0] A_FLAG    = 6'h10;
  localparam logic [ADDR_W-1:0] A_FLAGCLR = 6'h14;
  localparam logic [ADDR_W-1:0] A_WIDTH   = 6'h18;
  localparam logic [ADDR_W-1:0] A_MASKA   = 6'h1C;
  localparam logic [ADDR_W-1:0] A_MASKB   = 6'h20;

  localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_4755;
  localparam logic [7:0]        CTRL_KEEP   = 8'hF3;

  typedef struct packed {
    logic       boot;
    logic [1:0] scope;
    logic       tick_sel;
    logic [1:0] rsvd;
    logic       rst_en;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/guard_counter.sv
module guard_counter #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick_sel,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic step;

  assign step   = run && (tick_sel ? tick : 1'b1);
  assign expire = !restart && step && (count < CNT_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= RELOAD_RST;
    end else if (restart || expire) begin
      count <= reload;
    end else if (step) begin
      count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/guard_regs.sv
module guard_regs
  import guard_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DOM_W  = 26,
  parameter int DOMB_W = 32,
  parameter int PW_W   = 8,
  parameter logic [CNT_W-1:0]  RELOAD_RST = '1,
  parameter logic [DOM_W-1:0]  MASKA_RST  = '1,
  parameter logic [DOMB_W-1:0] MASKB_RST  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic [PW_W-1:0]   width,
  output logic [DOM_W-1:0]  mask_a,
  output logic [DOMB_W-1:0] mask_b,
  output logic              flag,
  output logic              restart
);
  logic [DATA_W-1:0] rd_next;

  assign restart = we && (addr == A_RESTART) && (wdata == RESTART_KEY);

  always_comb begin
    rd_next = '0;
    case (addr)
      A_COUNT:  rd_next[CNT_W-1:0]  = count;
      A_RELOAD: rd_next[CNT_W-1:0]  = reload;
      A_CTRL:   rd_next[7:0]        = ctrl;
      A_FLAG:   rd_next[0]          = flag;
      A_WIDTH:  rd_next[PW_W-1:0]   = width;
      A_MASKA:  rd_next[DOM_W-1:0]  = mask_a;
      A_MASKB:  rd_next[DOMB_W-1:0] = mask_b;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      ctrl   <= '0;
      reload <= RELOAD_RST;
      width  <= '1;
      mask_a <= MASKA_RST;
      mask_b <= MASKB_RST;
      flag   <= 1'b0;
    end else begin
      rdata <= rd_next;
      if (we) begin
        case (addr)
          A_RELOAD: reload <= wdata[CNT_W-1:0];
          A_CTRL:   ctrl   <= ctrl_t'(wdata[7:0] & CTRL_KEEP);
          A_WIDTH:  width  <= wdata[PW_W-1:0];
          A_MASKA:  mask_a <= wdata[DOM_W-1:0];
          A_MASKB:  mask_b <= wdata[DOMB_W-1:0];
          default: ;
        endcase
      end
      if (expire) begin
        ctrl.run <= 1'b0;
      end
      if (expire) begin
        flag <= 1'b1;
      end else if (we && (addr == A_FLAGCLR) && wdata[0]) begin
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/guard_rstgen.sv
module guard_rstgen #(
  parameter int DOM_W  = 26,
  parameter int DOMB_W = 32,
  parameter int PW_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              expire,
  input  logic              rst_en,
  input  logic [PW_W-1:0]   width,
  input  logic [1:0]        scope,
  input  logic [DOM_W-1:0]  mask_a,
  input  logic [DOMB_W-1:0] mask_b,
  output logic              pulse,
  output logic [1:0]        scope_o,
  output logic [DOM_W-1:0]  dom_a,
  output logic [DOMB_W-1:0] dom_b
);
  logic [PW_W-1:0]   left_q;
  logic [DOM_W-1:0]  cap_a;
  logic [DOMB_W-1:0] cap_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      scope_o <= '0;
      cap_a   <= '0;
      cap_b   <= '0;
    end else if (expire && rst_en) begin
      left_q  <= (width == '0) ? PW_W'(1) : width;
      scope_o <= scope;
      cap_a   <= mask_a;
      cap_b   <= mask_b;
    end else if (left_q != '0) begin
      left_q <= left_q - PW_W'(1);
    end
  end

  assign pulse = (left_q != '0);
  assign dom_a = cap_a & {DOM_W{pulse}};
  assign dom_b = cap_b & {DOMB_W{pulse}};
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DOM_W  = 26,
  parameter int DOMB_W = 32,
  parameter int PW_W   = 8,
  parameter logic [CNT_W-1:0]  RELOAD_RST = 32'h00FF_FFFF,
  parameter logic [DOM_W-1:0]  MASKA_RST  = 26'h23F_FFF3,
  parameter logic [DOMB_W-1:0] MASKB_RST  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              timeout_o,
  output logic              rst_o,
  output logic [1:0]        rst_scope_o,
  output logic [DOM_W-1:0]  rst_dom_a_o,
  output logic [DOMB_W-1:0] rst_dom_b_o
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  count_q;
  logic [PW_W-1:0]   width_q;
  logic [DOM_W-1:0]  mask_a_q;
  logic [DOMB_W-1:0] mask_b_q;
  logic              restart_w;
  logic              expire_w;
  logic              run_w;
  logic              rst_en_w;

  assign run_w    = ctrl_q.run;
  assign rst_en_w = ctrl_q.rst_en;

  guard_regs #(
    .CNT_W(CNT_W), .DOM_W(DOM_W), .DOMB_W(DOMB_W), .PW_W(PW_W),
    .RELOAD_RST(RELOAD_RST), .MASKA_RST(MASKA_RST), .MASKB_RST(MASKB_RST)
  ) regs_i (
    .clk(clk), .rst(rst), .addr(addr_i), .we(wr_en_i), .wdata(wr_data_i),
    .count(count_q), .expire(expire_w), .rdata(rd_data_o), .ctrl(ctrl_q),
    .reload(reload_q), .width(width_q), .mask_a(mask_a_q), .mask_b(mask_b_q),
    .flag(timeout_o), .restart(restart_w)
  );

  guard_counter #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) cnt_i (
    .clk(clk), .rst(rst), .run(run_w), .tick_sel(ctrl_q.tick_sel),
    .tick(tick_i), .restart(restart_w), .reload(reload_q),
    .count(count_q), .expire(expire_w)
  );

  guard_rstgen #(.DOM_W(DOM_W), .DOMB_W(DOMB_W), .PW_W(PW_W)) rgen_i (
    .clk(clk), .rst(rst), .expire(expire_w), .rst_en(rst_en_w),
    .width(width_q), .scope(ctrl_q.scope), .mask_a(mask_a_q), .mask_b(mask_b_q),
    .pulse(rst_o), .scope_o(rst_scope_o), .dom_a(rst_dom_a_o), .dom_b(rst_dom_b_o)
  );
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int DOM_W  = 26,
  parameter int DOMB_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              rst_en,
  input logic              restart,
  input logic              expire,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic              timeout,
  input logic              pulse,
  input logic [DOM_W-1:0]  dom_a,
  input logic [DOMB_W-1:0] dom_b
);
  // R2
  restart_load_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (count == $past(reload)));

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(count));

  // R4
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> !run);

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> timeout);

  // R6
  pulse_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(expire && rst_en));

  // R7
  dom_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !pulse |-> (dom_a == '0 && dom_b == '0));

  // R10
  restart_wins_chk: assert property (@(posedge clk) disable iff (rst)
    restart |-> !expire);
endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W), .DOM_W(DOM_W), .DOMB_W(DOMB_W)) chk_i (
  .clk(clk), .rst(rst), .run(run_w), .rst_en(rst_en_w), .restart(restart_w),
  .expire(expire_w), .count(count_q), .reload(reload_q), .timeout(timeout_o),
  .pulse(rst_o), .dom_a(rst_dom_a_o), .dom_b(rst_dom_b_o)
);

// File: tb/guard_timer_tb.sv
module guard_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RLD_RST = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        timeout;
  logic        rst_o;
  logic [1:0]  scope;
  logic [25:0] dom_a;
  logic [31:0] dom_b;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  guard_timer #(.RELOAD_RST(RLD_RST)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .addr_i(addr), .wr_en_i(we),
    .wr_data_i(wdata), .rd_data_o(rdata), .timeout_o(timeout), .rst_o(rst_o),
    .rst_scope_o(scope), .rst_dom_a_o(dom_a), .rst_dom_b_o(dom_b)
  );

  // tick every fourth clock
  int tphase = 0;
  always @(negedge clk) begin
    tphase = (tphase + 1) % 4;
    tick = (tphase == 0);
  end

  // behavioural reference model
  logic [31:0] m_cnt, m_rel, m_rd, m_m2, m_pm2;
  logic [25:0] m_m1, m_pm1;
  logic [7:0]  m_width;
  logic [1:0]  m_scope, m_pscope;
  logic        m_run, m_ren, m_tick, m_boot, m_flag;
  int          m_left;
  bit          live = 0;

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_cnt;
      6'h04: return m_rel;
      6'h0C: return {24'd0, m_boot, m_scope, m_tick, 2'b00, m_ren, m_run};
      6'h10: return {31'd0, m_flag};
      6'h18: return {24'd0, m_width};
      6'h1C: return {6'd0, m_m1};
      6'h20: return m_m2;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = RLD_RST; m_rel = RLD_RST; m_run = 0; m_ren = 0; m_tick = 0;
      m_scope = 0; m_boot = 0; m_flag = 0; m_width = 8'hFF;
      m_m1 = 26'h23FFFF3; m_m2 = 0; m_left = 0; m_pscope = 0;
      m_pm1 = 0; m_pm2 = 0; m_rd = 0; live = 1;
    end else begin
      bit rs, st, ex;
      m_rd = m_read(addr);
      rs = we && addr == 6'h08 && wdata == 32'h4755;
      st = m_run && (m_tick ? tick : 1'b1);
      ex = 0;
      if (rs) m_cnt = m_rel;
      else if (st) begin
        if (m_cnt < 2) begin ex = 1; m_cnt = m_rel; end
        else m_cnt = m_cnt - 1;
      end
      if (ex && m_ren) begin
        m_left = (m_width == 0) ? 1 : int'(m_width);
        m_pscope = m_scope; m_pm1 = m_m1; m_pm2 = m_m2;
      end else if (m_left > 0) m_left = m_left - 1;
      if (ex) m_flag = 1;
      else if (we && addr == 6'h14 && wdata[0]) m_flag = 0;
      if (we) begin
        case (addr)
          6'h04: m_rel = wdata;
          6'h0C: begin
            m_run = wdata[0]; m_ren = wdata[1]; m_tick = wdata[4];
            m_scope = wdata[6:5]; m_boot = wdata[7];
          end
          6'h18: m_width = wdata[7:0];
          6'h1C: m_m1 = wdata[25:0];
          6'h20: m_m2 = wdata;
          default: ;
        endcase
      end
      if (ex) m_run = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live && !rst) begin
      chk("R5 timeout_o", {31'd0, timeout}, {31'd0, m_flag});
      chk("R6 rst_o", {31'd0, rst_o}, {31'd0, (m_left > 0)});
      chk("R7 scope", {30'd0, scope}, {30'd0, m_pscope});
      chk("R7 dom_a", {6'd0, dom_a}, (m_left > 0) ? {6'd0, m_pm1} : 32'd0);
      chk("R7 dom_b", dom_b, (m_left > 0) ? m_pm2 : 32'd0);
      chk("R9 rd_data", rdata, m_rd);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse_len(output int n, output logic [1:0] sc, output logic [25:0] da);
    n = 0; sc = 0; da = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rst_o) begin n++; sc = scope; da = dom_a; end
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    logic [1:0] sc;
    logic [25:0] da;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values, R9 readback of unreadable offsets
    rd(6'h00, v); chk("R1 count", v, RLD_RST);
    rd(6'h04, v); chk("R1 reload", v, RLD_RST);
    rd(6'h0C, v); chk("R1 ctrl", v, 32'h0);
    rd(6'h10, v); chk("R1 flag", v, 32'h0);
    rd(6'h18, v); chk("R1 width", v, 32'hFF);
    rd(6'h1C, v); chk("R1 mask_a", v, 32'h023FFFF3);
    rd(6'h20, v); chk("R1 mask_b", v, 32'h0);
    chk("R1 rst_o", {31'd0, rst_o}, 32'd0);
    rd(6'h08, v); chk("R9 restart reads 0", v, 32'h0);
    rd(6'h24, v); chk("R9 unmapped reads 0", v, 32'h0);

    // R2 key word
    wr(6'h04, 32'd5);
    wr(6'h08, 32'h4756);
    rd(6'h00, v); chk("R2 wrong key ignored", v, RLD_RST);
    wr(6'h08, 32'h0001_4755);
    rd(6'h00, v); chk("R2 upper bits ignored", v, RLD_RST);
    wr(6'h08, 32'h4755);
    rd(6'h00, v); chk("R2 key reloads", v, 32'd5);

    // R3/R4 per-clock expiry, no reset pulse (R6)
    wr(6'h0C, 32'h01);
    repeat (8) @(negedge clk);
    rd(6'h10, v); chk("R4 flag set", v, 32'd1);
    rd(6'h0C, v); chk("R4 run cleared", v, 32'd0);
    rd(6'h00, v); chk("R4 counter reloaded", v, 32'd5);
    chk("R6 no pulse without enable", {31'd0, rst_o}, 32'd0);

    // R5 clear
    wr(6'h14, 32'h2);
    rd(6'h10, v); chk("R5 bit0 clear ignored", v, 32'd1);
    wr(6'h14, 32'h1);
    rd(6'h10, v); chk("R5 cleared", v, 32'd0);

    // R3 tick mode
    wr(6'h08, 32'h4755);
    wr(6'h0C, 32'h11);
    repeat (4) @(negedge clk);
    rd(6'h00, v); chk("R3 tick mode slow", {31'd0, (v >= 32'd3)}, 32'd1);
    repeat (30) @(negedge clk);
    rd(6'h10, v); chk("R3 tick mode expiry", v, 32'd1);
    wr(6'h14, 32'h1);

    // R6/R7 zero width gives one cycle
    wr(6'h18, 32'h0);
    wr(6'h1C, 32'h15);
    wr(6'h20, 32'hA5A5);
    wr(6'h04, 32'd2);
    wr(6'h08, 32'h4755);
    wr(6'h0C, 32'h43);
    pulse_len(n, sc, da);
    chk("R6 zero width", n, 32'd1);
    chk("R7 scope 2", {30'd0, sc}, 32'd2);
    chk("R7 domain a", {6'd0, da}, 32'h15);

    // R6 width 3, scope 1
    wr(6'h14, 32'h1);
    wr(6'h18, 32'h3);
    wr(6'h08, 32'h4755);
    wr(6'h0C, 32'h23);
    pulse_len(n, sc, da);
    chk("R6 width 3", n, 32'd3);
    chk("R7 scope 1", {30'd0, sc}, 32'd1);

    // R6 reset disabled
    wr(6'h08, 32'h4755);
    wr(6'h0C, 32'h01);
    pulse_len(n, sc, da);
    chk("R6 disabled", n, 32'd0);

    // R8 reload during run
    wr(6'h14, 32'h1);
    wr(6'h04, 32'd40);
    wr(6'h08, 32'h4755);
    wr(6'h0C, 32'h01);
    repeat (3) @(negedge clk);
    wr(6'h04, 32'd2);
    rd(6'h00, v); chk("R8 counter untouched", {31'd0, (v > 32'd2 && v < 32'd40)}, 32'd1);
    repeat (50) @(negedge clk);
    wr(6'h08, 32'h4755);
    rd(6'h00, v); chk("R8 new reload used", v, 32'd2);

    // R10 restart beats expiry
    wr(6'h14, 32'h1);
    wr(6'h04, 32'd1);
    wr(6'h08, 32'h4755);
    @(negedge clk); addr = 6'h0C; we = 1'b1; wdata = 32'h01;
    @(negedge clk); addr = 6'h08; wdata = 32'h4755;
    repeat (10) @(negedge clk);
    chk("R10 no timeout while restarting", {31'd0, timeout}, 32'd0);
    we = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 expires after restarts stop", {31'd0, timeout}, 32'd1);

    // R9 control readback keeps only defined bits
    wr(6'h0C, 32'hFC);
    rd(6'h0C, v); chk("R9 ctrl readback", v, 32'hF0);

    // R4 expire-now polling
    wr(6'h0C, 32'h00);
    wr(6'h04, 32'd1);
    wr(6'h08, 32'h4755);
    wr(6'h0C, 32'h03);
    v = 32'h1;
    for (int i = 0; i < 20 && v[0]; i++) rd(6'h0C, v);
    chk("R4 poll sees run clear", {31'd0, v[0]}, 32'd0);
    repeat (300) @(negedge clk);

    finish_run();
  end
endmodule